// File: doc/BRIEF.md
# Count-Extended DMA Address Generator

This block sits inside a DMA channel whose address register is only 18 bits wide. It lets the channel reach a physical memory four times larger without adding a separate high-address register. When a transfer starts, the two extra physical address bits are computed from the channel's own word count. The count is kept as a negative number that climbs toward zero, and the extra bits are the inverted top two bits of that count. A short block has a count whose top bits are all ones, so the extra bits come out as zero and the transfer lands in low memory. Software that never asks for a large count therefore behaves exactly as it did on an 18-bit channel.

An `extDisable` input is sampled when a transfer starts. When it is high, the extra bits are forced to zero and the channel behaves as a plain 18-bit device. The block holds the address register, the count register and the latched extension bits. It advances the address and count once for every word the memory side acknowledges. It signals completion with a done flag and a one-cycle interrupt request. Bus timing and control-word fetches happen outside the block.

Top module: `dma_cntext_top`

## Requirements
- R1: After reset, `busy`, `done` and `irq` are 0, and `physAddr` and `curCount` are 0.
- R2: A `start` taken while the block is not busy loads `startAddr` into `physAddr[17:0]` and `startCount` into `curCount`. When `startCount` is nonzero, `busy` is 1 from the next cycle.
- R3: With `extDisable` low at start, `physAddr[19:18]` equals the bitwise inverse of `startCount[13:12]`. Top bits 2'b11 therefore give extension 0, and 2'b00 gives extension 3.
- R4: With `extDisable` high at start, `physAddr[19:18]` is 0 for the whole transfer.
- R5: Each cycle with `wordAck` high while busy adds one to `physAddr[17:0]`, wrapping modulo 2^18 without touching bits [19:18], and adds one to `curCount`.
- R6: `physAddr[19:18]` does not change during a transfer. This holds while the count crosses into a range with different top bits, and when `extDisable` toggles.
- R7: The acknowledged word that brings `curCount` to zero makes `busy` fall and `done` rise in the same cycle. `irq` is high for exactly that one cycle.
- R8: `start` while busy is ignored: address, count, extension and `busy` are unaffected.
- R9: A `start` with `startCount` zero leaves `busy` at 0, sets `done`, and pulses `irq` for one cycle.
- R10: `wordAck` while not busy changes neither `physAddr` nor `curCount`.
- R11: An accepted `start` with nonzero count clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| startAddr | input | 18 | First word address |
| startCount | input | 14 | Negative word count (two's complement) |
| extDisable | input | 1 | Forces extension bits to zero, sampled at start |
| wordAck | input | 1 | One word transferred this cycle |
| physAddr | output | 20 | Physical address: extension bits over channel address |
| curCount | output | 14 | Current count register |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |
| irq | output | 1 | One-cycle completion request |

## Verification
The bench runs transfers whose starting counts fall in each of the four top-bit ranges. This separates an inverted mapping of the count bits from a direct or swapped one. Several counts begin just below a range boundary, so the count crosses into a new top-bit range mid-transfer; this exposes a design that recomputes the extension instead of latching it. Each count is run with the disable both low and high, and the disable is toggled after start. A start address next to the 18-bit limit shows whether the carry stays out of the extension bits. Acknowledges arrive with gaps, and starts are issued during transfers, which tells a correct stepping and start-ignore rule apart from one that advances on every cycle or reloads.

// File: rtl/dma_cntext_pkg.sv
package dma_cntext_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } ctrlStrobes_t;
endpackage

// File: rtl/dma_cntext_dp.sv
module dma_cntext_dp
  import dma_cntext_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 14,
  parameter int EXT_W  = 2,
  localparam int PHYS_W = ADDR_W + EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  startCount,
  input  logic              extDisable,
  output logic              startZero,
  output logic              countLast,
  output logic [PHYS_W-1:0] physAddr,
  output logic [CNT_W-1:0]  curCount
);
  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  countQ;
  logic [EXT_W-1:0]  extQ;
  logic [EXT_W-1:0]  extNext;

  assign extNext   = extDisable ? '0 : ~startCount[CNT_W-1 -: EXT_W];
  assign startZero = (startCount == '0);
  assign countLast = (countQ == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ  <= '0;
      countQ <= '0;
      extQ   <= '0;
    end else if (strb.load) begin
      addrQ  <= startAddr;
      countQ <= startCount;
      extQ   <= extNext;
    end else if (strb.step) begin
      addrQ  <= addrQ + 1'b1;
      countQ <= countQ + 1'b1;
    end
  end

  assign physAddr = {extQ, addrQ};
  assign curCount = countQ;

  p_step_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.step && !strb.load |=> physAddr[ADDR_W-1:0] == $past(physAddr[ADDR_W-1:0]) + 1'b1);
  p_step_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.step && !strb.load |=> curCount == $past(curCount) + 1'b1);
  p_ext_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load |=> $stable(physAddr[PHYS_W-1:ADDR_W]));
  p_ext_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load && extDisable |=> physAddr[PHYS_W-1:ADDR_W] == '0);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load && !strb.step |=> $stable(physAddr) && $stable(curCount));
endmodule

// File: rtl/dma_cntext_ctrl.sv
module dma_cntext_ctrl
  import dma_cntext_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         wordAck,
  input  logic         startZero,
  input  logic         countLast,
  output ctrlStrobes_t strb,
  output logic         busy,
  output logic         done,
  output logic         irq
);
  logic finish;

  assign strb.load = start && !busy;
  assign strb.step = wordAck && busy;
  assign finish    = strb.step && countLast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      irq  <= 1'b0;
    end else if (strb.load) begin
      busy <= !startZero;
      done <= startZero;
      irq  <= startZero;
    end else if (finish) begin
      busy <= 1'b0;
      done <= 1'b1;
      irq  <= 1'b1;
    end else begin
      irq  <= 1'b0;
    end
  end

  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_irq_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done && !busy);
  p_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> irq && done && !busy);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !finish |=> busy);
  p_zero_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && startZero |=> !busy && done && irq);
endmodule

// File: rtl/dma_cntext_top.sv
module dma_cntext_top
  import dma_cntext_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 14,
  parameter int EXT_W  = 2,
  localparam int PHYS_W = ADDR_W + EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  startCount,
  input  logic              extDisable,
  input  logic              wordAck,
  output logic [PHYS_W-1:0] physAddr,
  output logic [CNT_W-1:0]  curCount,
  output logic              busy,
  output logic              done,
  output logic              irq
);
  ctrlStrobes_t strb;
  logic startZero;
  logic countLast;

  dma_cntext_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .wordAck(wordAck),
    .startZero(startZero), .countLast(countLast), .strb(strb),
    .busy(busy), .done(done), .irq(irq)
  );

  dma_cntext_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .EXT_W(EXT_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .startAddr(startAddr),
    .startCount(startCount), .extDisable(extDisable),
    .startZero(startZero), .countLast(countLast),
    .physAddr(physAddr), .curCount(curCount)
  );
endmodule

// File: tb/test_dma_cntext_top.sv
module test_dma_cntext_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [17:0] startAddr = '0;
  logic [13:0] startCount = '0;
  logic        extDisable = 1'b0;
  logic        wordAck = 1'b0;
  logic [19:0] physAddr;
  logic [13:0] curCount;
  logic        busy, done, irq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_cntext_top i_dma_cntext_top (
    .clk(clk), .rst_n(rst_n), .start(start), .startAddr(startAddr),
    .startCount(startCount), .extDisable(extDisable), .wordAck(wordAck),
    .physAddr(physAddr), .curCount(curCount), .busy(busy), .done(done), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runXfer(input logic [17:0] a, input logic [13:0] c, input bit dis);
    logic [1:0]  expExt;
    logic [17:0] expAddr;
    logic [13:0] expCnt;
    bit ack;
    int k;
    @(negedge clk);
    start = 1'b1; startAddr = a; startCount = c; extDisable = dis; wordAck = 1'b0;
    @(negedge clk);
    start = 1'b0;
    expExt = dis ? 2'b00 : ~c[13:12];
    if (c == 14'd0) begin
      check(!busy && done && irq, "R9 zero-count start", {busy, done, irq}, 3'b011);
      @(negedge clk);
      check(!irq && done, "R9 irq one cycle", {irq, done}, 2'b01);
      return;
    end
    check(physAddr == {expExt, a} && curCount == c, dis ? "R4 load ext forced" : "R3 R2 load",
          {physAddr, curCount}, {expExt, a, c});
    check(busy && !done && !irq, "R2 R11 busy set done cleared", {busy, done, irq}, 3'b100);
    extDisable = !dis;
    expAddr = a; expCnt = c; k = 0;
    while (expCnt != 14'd0) begin
      ack = (k % 3) != 2;
      wordAck = ack;
      start = (k % 5) == 0;
      startAddr = ~a; startCount = ~c;
      @(negedge clk);
      if (ack) begin
        expAddr = expAddr + 18'd1;
        expCnt = expCnt + 14'd1;
      end
      check(physAddr == {expExt, expAddr} && curCount == expCnt, "R5 R6 R8 step",
            {physAddr, curCount}, {expExt, expAddr, expCnt});
      check(busy == (expCnt != 0) && done == (expCnt == 0) && irq == (expCnt == 0),
            "R7 R8 flags", {busy, done, irq}, {expCnt != 0, expCnt == 0, expCnt == 0});
      k++;
    end
    start = 1'b0; wordAck = 1'b1;
    @(negedge clk);
    wordAck = 1'b0;
    check(!irq && done && !busy, "R7 irq one cycle", {busy, done, irq}, 3'b010);
    check(physAddr == {expExt, expAddr} && curCount == 14'd0, "R10 ack while idle",
          {physAddr, curCount}, {expExt, expAddr, 14'd0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(physAddr == 20'd0 && curCount == 14'd0 && !busy && !done && !irq, "R1 reset",
          {physAddr, curCount, busy, done, irq}, 37'd0);
    rst_n = 1'b1;
    wordAck = 1'b1;
    @(negedge clk);
    wordAck = 1'b0;
    check(physAddr == 20'd0 && curCount == 14'd0 && !busy, "R10 ack after reset",
          {physAddr, curCount}, 34'd0);
    for (int d = 0; d < 2; d++) begin
      runXfer(18'h00100, 14'h3FFF, d[0]);
      runXfer(18'h3FFFE, 14'h3FFB, d[0]);
      runXfer(18'h01230, 14'h2FFD, d[0]);
      runXfer(18'h2AAA0, 14'h1FFE, d[0]);
      runXfer(18'h15550, 14'h0FFC, d[0]);
      runXfer(18'h00000, 14'h0000, d[0]);
      runXfer(18'h3FFF0, 14'h3000, d[0]);
    end
    runXfer(18'h20000, 14'h2000, 1'b0);
    finished = 1'b1;
  end

  initial begin
    for (int i = 0; i < 190000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule